// File: doc/BRIEF.md
# Parallel Flash Programming Host Controller

This block is a host-side engine for a byte-wide asynchronous flash part. A client hands it one request at a time through a valid/ready port: read a byte, program a byte, or erase the whole chip. The engine drives the flash address bus, the data bus with its drive enable, and the chip-enable, write-enable and output-enable strobes (all active low). Every timing phase is a cycle count that the integrator sets from the flash grade and the clock period.

A program request issues a three-write unlock and command prefix and then writes the byte. An erase request issues a six-write sequence. After the writes, the engine reads the target location again and again. Each read compares bit 7 with the value that the finished operation leaves there: the programmed byte's bit 7, or 1 after an erase. A poll limit turns a part that never completes into an error response. A plain read performs one bus read and returns the byte.

Top module: `flash_host_ctrl`

## Requirements
- R1: Op code 0 (and 3) performs exactly one bus read of `req_addr_i` and returns the byte on `rsp_data_o` with `rsp_error_o` low.
- R2: Op code 1 issues four bus writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (`req_addr_i`, `req_data_i`).
- R3: Op code 2 issues six bus writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R4: In each write, address and data are driven with the strobes high for `cfg_setup_i`+1 cycles. CE# and WE# are then low together for `cfg_pulse_i`+1 cycles with address and data stable. The strobes then return high for `cfg_recov_i`+1 cycles while address and data are still driven.
- R5: OE# is high whenever WE# is low. The data driver is enabled only in write phases and never while OE# is low.
- R6: Every read is preceded by at least one cycle with the data driver off and all strobes high. CE# and OE# then stay low for `cfg_access_i`+1 cycles, and the data is sampled in the last of those cycles.
- R7: After OE# rises, the strobes stay high for `cfg_float_i`+1 cycles, plus the idle cycle of R6, before the next poll read starts.
- R8: Program and erase complete successfully at the first poll read whose bit 7 equals the expected value (the written bit 7, or 1 for erase); `rsp_data_o` carries that read.
- R9: If max(`cfg_timeout_i`,1) poll reads all mismatch, the request completes with `rsp_error_o` high and no further read.
- R10: A match on the last allowed poll read completes without error.
- R11: `req_ready_o` is high only while idle; a request is accepted on valid and ready, and `rsp_valid_o` is a single-cycle pulse per request.
- R12: During reset, the strobes are high, the driver is off and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_op_i | input | 2 | 0/3 read, 1 program, 2 erase |
| req_addr_i | input | ADDR_W | Target address |
| req_data_i | input | 8 | Byte to program |
| cfg_setup_i | input | CNT_W | Write setup cycles minus one |
| cfg_pulse_i | input | CNT_W | Write strobe low cycles minus one |
| cfg_recov_i | input | CNT_W | Write strobe high cycles minus one |
| cfg_access_i | input | CNT_W | Read access cycles minus one |
| cfg_float_i | input | CNT_W | Bus release cycles minus one |
| cfg_timeout_i | input | TMO_W | Maximum number of poll reads |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_error_o | output | 1 | Poll limit reached without completion |
| rsp_data_o | output | 8 | Last byte read |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Flash data driver enable |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |

## Verification
The poll comparison and the poll limit are decided in the same cycle, when the final read of a poll closes. The bench provokes this collision by making the model flash busy for exactly one read fewer than the limit. The last allowed read then both matches and exhausts the limit, and a correct engine reports success. A second run keeps the part busy past the limit and counts the reads to confirm that the error appears after exactly that many.

// File: rtl/flash_host_pkg.sv
package flash_host_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV,
    ST_RTURN,
    ST_RACC,
    ST_RFLOAT
  } state_e;

  localparam int unsigned PROG_WRITES  = 4;
  localparam int unsigned ERASE_WRITES = 6;
  localparam int unsigned IDX_W        = 3;
  localparam logic [14:0] UNLOCK_A     = 15'h5555;
  localparam logic [14:0] UNLOCK_B     = 15'h2AAA;
endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/flash_unlock_rom.sv
module flash_unlock_rom
  import flash_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  op_e                      op_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [ADDR_W-1:0]        tgt_addr_i,
  input  logic [7:0]               tgt_data_i,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [7:0]               wr_data_o,
  output logic                     last_o
);
  localparam logic [ADDR_W-1:0] A_5 = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] A_2 = ADDR_W'(UNLOCK_B);

  always_comb begin
    wr_addr_o = A_5;
    wr_data_o = 8'hAA;
    last_o    = 1'b0;
    if (op_i == OP_ERASE) begin
      case (idx_i)
        3'd0: begin wr_addr_o = A_5; wr_data_o = 8'hAA; end
        3'd1: begin wr_addr_o = A_2; wr_data_o = 8'h55; end
        3'd2: begin wr_addr_o = A_5; wr_data_o = 8'h80; end
        3'd3: begin wr_addr_o = A_5; wr_data_o = 8'hAA; end
        3'd4: begin wr_addr_o = A_2; wr_data_o = 8'h55; end
        default: begin wr_addr_o = A_5; wr_data_o = 8'h10; end
      endcase
      last_o = (32'(idx_i) >= ERASE_WRITES - 1);
    end else begin
      case (idx_i)
        3'd0: begin wr_addr_o = A_5; wr_data_o = 8'hAA; end
        3'd1: begin wr_addr_o = A_2; wr_data_o = 8'h55; end
        3'd2: begin wr_addr_o = A_5; wr_data_o = 8'hA0; end
        default: begin wr_addr_o = tgt_addr_i; wr_data_o = tgt_data_i; end
      endcase
      last_o = (32'(idx_i) >= PROG_WRITES - 1);
    end
  end
endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             expect_i,
  input  logic             sample_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             match_o,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign match_o   = (sample_i == expect_i);
  assign expired_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};

  assert_poll_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !expired_o);
endmodule

// File: rtl/flash_host_ctrl.sv
module flash_host_ctrl
  import flash_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic [CNT_W-1:0]  cfg_setup_i,
  input  logic [CNT_W-1:0]  cfg_pulse_i,
  input  logic [CNT_W-1:0]  cfg_recov_i,
  input  logic [CNT_W-1:0]  cfg_access_i,
  input  logic [CNT_W-1:0]  cfg_float_i,
  input  logic [TMO_W-1:0]  cfg_timeout_i,
  output logic              rsp_valid_o,
  output logic              rsp_error_o,
  output logic [7:0]        rsp_data_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);
  state_e             state_q, state_d;
  op_e                op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q, rd_q;
  logic [IDX_W-1:0]   idx_q;
  logic               rsp_valid_q, rsp_err_q;

  logic               phase_done, tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [ADDR_W-1:0]  rom_addr;
  logic [7:0]         rom_data;
  logic               rom_last;
  logic               poll_match, poll_expired, poll_step, poll_clear;
  logic               is_read, finish, finish_err, accept;

  assign is_read = (op_q == OP_READ) || (op_q == OP_READ2);
  assign accept  = (state_q == ST_IDLE) && req_valid_i;

  flash_unlock_rom #(.ADDR_W(ADDR_W)) u_rom (
    .op_i      (op_q),
    .idx_i     (idx_q),
    .tgt_addr_i(addr_q),
    .tgt_data_i(data_q),
    .wr_addr_o (rom_addr),
    .wr_data_o (rom_data),
    .last_o    (rom_last)
  );

  flash_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (phase_done)
  );

  flash_poll_judge #(.TMO_W(TMO_W)) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (poll_clear),
    .step_i   (poll_step),
    .expect_i ((op_q == OP_ERASE) ? 1'b1 : data_q[7]),
    .sample_i (rd_q[7]),
    .limit_i  (cfg_timeout_i),
    .match_o  (poll_match),
    .expired_o(poll_expired)
  );

  always_comb begin
    state_d    = state_q;
    finish     = 1'b0;
    finish_err = 1'b0;
    poll_step  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i)
                   state_d = (op_e'(req_op_i) == OP_PROG || op_e'(req_op_i) == OP_ERASE)
                             ? ST_WSETUP : ST_RTURN;
      ST_WSETUP: if (phase_done) state_d = ST_WPULSE;
      ST_WPULSE: if (phase_done) state_d = ST_WRECOV;
      ST_WRECOV: if (phase_done) state_d = rom_last ? ST_RTURN : ST_WSETUP;
      ST_RTURN:  if (phase_done) state_d = ST_RACC;
      ST_RACC:   if (phase_done) state_d = ST_RFLOAT;
      ST_RFLOAT: if (phase_done) begin
                   if (is_read || poll_match) begin
                     state_d = ST_IDLE; finish = 1'b1;
                   end else if (poll_expired) begin
                     state_d = ST_IDLE; finish = 1'b1; finish_err = 1'b1;
                   end else begin
                     state_d = ST_RTURN; poll_step = 1'b1;
                   end
                 end
      default:   state_d = ST_IDLE;
    endcase
  end

  // every phase change reloads the timer: a phase lasts cfg+1 cycles
  assign tmr_load   = (state_d != state_q) || (state_q == ST_WRECOV && phase_done);
  assign poll_clear = accept;

  always_comb begin
    unique case (state_d)
      ST_WSETUP: tmr_val = cfg_setup_i;
      ST_WPULSE: tmr_val = cfg_pulse_i;
      ST_WRECOV: tmr_val = cfg_recov_i;
      ST_RACC:   tmr_val = cfg_access_i;
      ST_RFLOAT: tmr_val = cfg_float_i;
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      data_q      <= '0;
      rd_q        <= '0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= finish;
      if (finish) rsp_err_q <= finish_err;
      if (accept) begin
        op_q   <= op_e'(req_op_i);
        addr_q <= req_addr_i;
        data_q <= req_data_i;
        idx_q  <= '0;
      end else if (state_q == ST_WRECOV && phase_done && !rom_last) begin
        idx_q <= idx_q + 1'b1;
      end
      if (state_q == ST_RACC && phase_done) rd_q <= fl_dq_i;
    end
  end

  logic wr_phase;
  assign wr_phase    = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) || (state_q == ST_WRECOV);
  assign fl_we_no    = (state_q != ST_WPULSE);
  assign fl_oe_no    = (state_q != ST_RACC);
  assign fl_ce_no    = !((state_q == ST_WPULSE) || (state_q == ST_RACC));
  assign fl_dq_oe_o  = wr_phase;
  assign fl_addr_o   = wr_phase ? rom_addr : addr_q;
  assign fl_dq_o     = rom_data;
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_error_o = rsp_err_q;
  assign rsp_data_o  = rd_q;

  assert_oe_high_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> fl_oe_no);
  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o);
  assert_bus_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));
  assert_turn_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_no) |-> !$past(fl_dq_oe_o));
  assert_single_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/flash_host_ctrl_test.sv
module flash_host_ctrl_test;
  localparam int ADDR_W = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]        req_data = '0;
  logic [7:0]        c_setup = 8'd1, c_pulse = 8'd3, c_recov = 8'd2, c_acc = 8'd2, c_float = 8'd1;
  logic [15:0]       c_tmo = 16'd10;
  logic              rsp_valid, rsp_error;
  logic [7:0]        rsp_data;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_dq_o, fl_dq_i;
  logic              fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  flash_host_ctrl #(.ADDR_W(ADDR_W), .CNT_W(8), .TMO_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .cfg_setup_i(c_setup), .cfg_pulse_i(c_pulse), .cfg_recov_i(c_recov),
    .cfg_access_i(c_acc), .cfg_float_i(c_float), .cfg_timeout_i(c_tmo),
    .rsp_valid_o(rsp_valid), .rsp_error_o(rsp_error), .rsp_data_o(rsp_data),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model
  logic [7:0] mem [16];
  int busy_left = 0, busy_cfg = 0;
  bit arm_prog = 0;
  assign fl_dq_i = (!fl_ce_n && !fl_oe_n)
                   ? ((busy_left > 0) ? {~mem[fl_addr[3:0]][7], mem[fl_addr[3:0]][6:0]} : mem[fl_addr[3:0]])
                   : 8'h00;

  // bus monitor, sampled at negedge
  int log_n = 0;
  logic [ADDR_W-1:0] log_a [8];
  logic [7:0] log_d [8];
  int n_reads = 0, run_p = 0, run_s = 0, run_r = 0, run_acc = 0, run_gap = 0;
  int last_pulse = 0, first_setup = 0, last_recov = 0, last_acc = 0, last_gap = 0;
  int viol_r5 = 0, viol_turn = 0, viol_busy = 0, rsp_run = 0, viol_pulse = 0;
  logic p_we = 1, p_oe = 1, p_oe_drv = 0;

  always @(negedge clk) begin
    cycles++;
    if (!fl_we_n && !fl_oe_n) viol_r5++;
    if (!fl_oe_n && fl_dq_oe) viol_r5++;
    if (fl_dq_oe && fl_we_n) run_s++;
    if (!fl_we_n && p_we) begin
      if (log_n == 0) first_setup = run_s;
    end
    if (!fl_we_n || !fl_dq_oe) run_s = 0;
    if (!fl_we_n) run_p++;
    if (fl_we_n && !p_we) begin
      last_pulse = run_p; run_p = 0; run_r = 1;
      if (log_n < 8) begin log_a[log_n] = fl_addr; log_d[log_n] = fl_dq_o; end
      log_n++;
      if (arm_prog) begin
        mem[fl_addr[3:0]] = fl_dq_o; busy_left = busy_cfg; arm_prog = 0;
      end else if (fl_dq_o == 8'hA0 && fl_addr == 19'h5555) arm_prog = 1;
      else if (fl_dq_o == 8'h10 && fl_addr == 19'h5555) begin
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        busy_left = busy_cfg;
      end
    end else if (fl_we_n && fl_dq_oe && run_r > 0) run_r++;
    if (!fl_dq_oe && p_oe_drv) begin last_recov = run_r; run_r = 0; end
    if (!fl_oe_n) run_acc++;
    if (fl_oe_n) run_gap++;
    if (!fl_oe_n && p_oe) begin
      if (p_oe_drv) viol_turn++;
      last_gap = run_gap;
    end
    if (fl_oe_n && !p_oe) begin
      last_acc = run_acc; run_acc = 0; run_gap = 1; n_reads++;
      if (busy_left > 0) busy_left--;
    end
    if ((!fl_ce_n) && req_ready) viol_busy++;
    if (rsp_valid) rsp_run++; else rsp_run = 0;
    if (rsp_run > 1) viol_pulse++;
    p_we = fl_we_n; p_oe = fl_oe_n; p_oe_drv = fl_dq_oe;
  end

  logic [7:0] got_d;
  bit got_e;

  task automatic run_req(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    int w;
    log_n = 0; n_reads = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!rsp_valid && w < 5000) begin @(negedge clk); w++; end
    chk(rsp_valid, "R11 response arrives", 0, 1);
    got_d = rsp_data; got_e = rsp_error;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready && fl_we_n && fl_ce_n && fl_oe_n && !fl_dq_oe, "R12 reset state",
        {req_ready, fl_we_n, fl_ce_n, fl_oe_n, fl_dq_oe}, 5'b11110);
  endtask

  task automatic t_read();
    mem[5] = 8'h3C;
    run_req(2'd0, 19'h5, 8'h00);
    chk(got_d == 8'h3C && !got_e, "R1 read data", got_d, 8'h3C);
    chk(n_reads == 1, "R1 one read", n_reads, 1);
    chk(last_acc == 3, "R6 access width", last_acc, 3);
    mem[9] = 8'hC3;
    run_req(2'd3, 19'h9, 8'h00);
    chk(got_d == 8'hC3 && n_reads == 1, "R1 op 3 read", got_d, 8'hC3);
  endtask

  task automatic t_program();
    logic [ADDR_W-1:0] ea [4];
    logic [7:0] ed [4];
    ea = '{19'h5555, 19'h2AAA, 19'h5555, 19'h7};
    ed = '{8'hAA, 8'h55, 8'hA0, 8'h5A};
    busy_cfg = 3; c_tmo = 16'd10;
    run_req(2'd1, 19'h7, 8'h5A);
    chk(log_n == 4, "R2 write count", log_n, 4);
    for (int i = 0; i < 4; i++)
      chk(log_a[i] == ea[i] && log_d[i] == ed[i], "R2 write entry",
          {log_a[i], log_d[i]}, {ea[i], ed[i]});
    chk(last_pulse == 4, "R4 pulse width", last_pulse, 4);
    chk(first_setup == 2, "R4 setup width", first_setup, 2);
    chk(last_recov == 3, "R4 recovery width", last_recov, 3);
    chk(n_reads == 4 && !got_e, "R8 poll until match", n_reads, 4);
    chk(got_d == 8'h5A, "R8 final data", got_d, 8'h5A);
    chk(last_gap == 3, "R7 float plus idle gap", last_gap, 3);
  endtask

  task automatic t_erase();
    logic [7:0] ed [6];
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    busy_cfg = 2;
    run_req(2'd2, 19'h3, 8'h00);
    chk(log_n == 6, "R3 write count", log_n, 6);
    for (int i = 0; i < 6; i++)
      chk(log_d[i] == ed[i] && log_a[i] == ((i == 1 || i == 4) ? 19'h2AAA : 19'h5555),
          "R3 write entry", {log_a[i], log_d[i]}, ed[i]);
    chk(n_reads == 3 && !got_e, "R8 erase poll", n_reads, 3);
    run_req(2'd0, 19'h7, 8'h00);
    chk(got_d == 8'hFF, "R8 erased data", got_d, 8'hFF);
  endtask

  task automatic t_timeout();
    busy_cfg = 50; c_tmo = 16'd5;
    run_req(2'd1, 19'h2, 8'h00);
    chk(got_e == 1'b1, "R9 error flag", got_e, 1);
    chk(n_reads == 5, "R9 read count", n_reads, 5);
    busy_left = 0;
  endtask

  task automatic t_exact();
    busy_cfg = 4; c_tmo = 16'd5;
    run_req(2'd1, 19'h4, 8'h00);
    chk(got_e == 1'b0, "R10 match on last read", got_e, 0);
    chk(n_reads == 5, "R10 read count", n_reads, 5);
    busy_left = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_read();
    t_program();
    t_erase();
    t_timeout();
    t_exact();
    chk(viol_r5 == 0, "R5 strobe and driver rules", viol_r5, 0);
    chk(viol_turn == 0, "R6 idle before read", viol_turn, 0);
    chk(viol_busy == 0 && viol_pulse == 0, "R11 ready and pulse", viol_busy + viol_pulse, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule